// File: doc/BRIEF.md
# Master-Clock Ratio Speed Detector

This block watches an asynchronous word (frame) clock from inside the master-clock domain and counts how many master-clock cycles make up one frame. The count is matched against the supported master-clock-to-frame ratios: 128, 192, 256, 384, 512, 768 and 1152. From the match it derives the sample-rate band: normal, double or quad speed. A converter's digital front end can then choose its filter and timing set without a mode register.

Each rising edge of the word clock closes one measurement window and opens the next. A window whose length falls outside every tolerance band is reported as unknown. Lock requires two matching windows in a row. The speed band only moves while lock holds, so a glitch or a stopped word clock never flips the band. The 1152 ratio belongs to the lowest sample rate only and always reports normal speed.

Top module: `mclk_rate_detect`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears to speed code 00 (normal), ratio code 0 (unknown) and `locked_o` low.
- R2: The ratio code on `ratio_o` is 1=128, 2=192, 3=256, 4=384, 5=512, 6=768, 7=1152 master clocks per frame, and 0=unknown. The code is refreshed at the end of every complete window.
- R3: A window length within plus or minus 4 cycles of a nominal ratio is reported as that ratio. Any other length, including 517 cycles, is reported as code 0.
- R4: The speed code on `speed_o` is 00 for normal (ratios 512, 768, 1152), 01 for double (256, 384) and 10 for quad (128, 192).
- R5: `locked_o` rises at the end of a window whose known ratio equals that of the window just before it. It falls at the end of any window that is unknown or differs from its predecessor.
- R6: `speed_o` takes a new value only at a window end that sets or keeps lock. While unlocked it holds its last value.
- R7: The cycle counter stops at 1201. In the cycle after it reaches that value, `locked_o` is low and `ratio_o` is 0, and this continues until new windows re-establish lock.
- R8: Suppose `wclk_async` is first sampled high at clock edge k after being sampled low at edge k-1. Then the window ends at edge k+2, and its length is the number of edges since the previous window end.
- R9: The stretch from reset to the first word-clock rising edge is not a window and produces no classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wclk_async | input | 1 | Word clock, asynchronous to `clk` |
| speed_o | output | 2 | Detected speed band: 00 normal, 01 double, 10 quad |
| ratio_o | output | 3 | Ratio code of the last completed window |
| locked_o | output | 1 | Two consecutive windows agreed on a known ratio |

## Verification
Each nominal ratio is applied for several frames in turn, so every ratio code and every speed band appears, and each one locks once two windows agree. Off-nominal frames of 508, 516 and 517 cycles show where the tolerance edge lies. Frames alternating between 512 and 768 show that lock drops on a mismatch while the speed band holds. A word clock held low past the counter limit, followed by a fresh rate, exercises saturation and recovery from a saturated window.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    localparam int CNT_W     = 12;
    localparam int NUM_RATIO = 7;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2
    } speed_e;

    typedef enum logic [2:0] {
        RT_NONE = 3'd0,
        RT_128  = 3'd1,
        RT_192  = 3'd2,
        RT_256  = 3'd3,
        RT_384  = 3'd4,
        RT_512  = 3'd5,
        RT_768  = 3'd6,
        RT_1152 = 3'd7
    } ratio_e;

    typedef struct packed {
        logic             done;   // a complete window ends this cycle
        logic             sat;    // counter sits at its limit
        logic [CNT_W-1:0] count;  // cycles since the previous window end
    } window_t;

    function automatic int nominal_of(int code);
        case (code)
            1:       return 128;
            2:       return 192;
            3:       return 256;
            4:       return 384;
            5:       return 512;
            6:       return 768;
            7:       return 1152;
            default: return 0;
        endcase
    endfunction

    function automatic speed_e speed_of(ratio_e r);
        case (r)
            RT_128, RT_192: return SPD_QUAD;
            RT_256, RT_384: return SPD_DOUBLE;
            default:        return SPD_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/wclk_edge_sync.sv
module wclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wclk_async,
    output logic rise
);
    localparam int W = STAGES + 1;

    logic [W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[W-2:0], wclk_async};
    end

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/window_counter.sv
module window_counter
    import mrd_pkg::*;
#(
    parameter int SAT_LIMIT = 1201
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    rise,
    output window_t win
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SAT_LIMIT);

    logic [CNT_W-1:0] cnt;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (rise) begin
            cnt   <= CNT_W'(1);
            armed <= 1'b1;
        end else if (cnt != LIMIT) begin
            cnt   <= cnt + CNT_W'(1);
        end
    end

    always_comb begin
        win.done  = rise & armed;
        win.sat   = (cnt == LIMIT);
        win.count = cnt;
    end

    a_r7_count_capped: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);

    a_r9_no_window_unarmed: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !win.done);

endmodule

// File: rtl/ratio_classify.sv
module ratio_classify
    import mrd_pkg::*;
#(
    parameter int TOL = 4
) (
    input  logic [CNT_W-1:0] count,
    output ratio_e           ratio
);
    logic [NUM_RATIO:1] hit;

    for (genvar i = 1; i <= NUM_RATIO; i++) begin : g_band
        localparam logic [CNT_W-1:0] LO = CNT_W'(nominal_of(i) - TOL);
        localparam logic [CNT_W-1:0] HI = CNT_W'(nominal_of(i) + TOL);
        assign hit[i] = (count >= LO) && (count <= HI);
    end

    always_comb begin
        ratio = RT_NONE;
        for (int j = 1; j <= NUM_RATIO; j++) begin
            if (hit[j]) ratio = ratio_e'(j);
        end
    end

endmodule

// File: rtl/mclk_rate_detect.sv
module mclk_rate_detect
    import mrd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TOL         = 4,
    parameter int SAT_LIMIT   = 1201
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wclk_async,
    output logic [1:0] speed_o,
    output logic [2:0] ratio_o,
    output logic       locked_o
);
    logic    rise;
    window_t win;
    ratio_e  cls;
    ratio_e  prev_q, ratio_q;
    speed_e  speed_q;
    logic    lock_q;

    wclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .wclk_async (wclk_async),
        .rise       (rise)
    );

    window_counter #(.SAT_LIMIT(SAT_LIMIT)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .rise (rise),
        .win  (win)
    );

    ratio_classify #(.TOL(TOL)) u_cls (
        .count (win.count),
        .ratio (cls)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= RT_NONE;
            ratio_q <= RT_NONE;
            speed_q <= SPD_NORMAL;
            lock_q  <= 1'b0;
        end else if (win.done) begin
            ratio_q <= cls;
            prev_q  <= cls;
            if (cls != RT_NONE && cls == prev_q) begin
                lock_q  <= 1'b1;
                speed_q <= speed_of(cls);
            end else begin
                lock_q  <= 1'b0;
            end
        end else if (win.sat) begin
            ratio_q <= RT_NONE;
            prev_q  <= RT_NONE;
            lock_q  <= 1'b0;
        end
    end

    assign speed_o  = speed_q;
    assign ratio_o  = ratio_q;
    assign locked_o = lock_q;

    a_r5_lock_known: assert property (@(posedge clk) disable iff (rst)
        locked_o |-> ratio_o != RT_NONE);

    a_r4_speed_matches: assert property (@(posedge clk) disable iff (rst)
        locked_o |-> speed_o == speed_of(ratio_e'(ratio_o)));

    a_r6_speed_hold: assert property (@(posedge clk) disable iff (rst)
        (!locked_o && !$past(rst)) |-> $stable(speed_o));

    a_r7_sat_unlocks: assert property (@(posedge clk) disable iff (rst)
        win.sat |=> (!locked_o && ratio_o == RT_NONE));

    a_r5_lock_at_window: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(win.done));

endmodule

// File: tb/mclk_rate_detect_test.sv
`timescale 1ns/100ps
module mclk_rate_detect_test;

    localparam int SAT = 1201;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wclk = 1'b0;
    logic [1:0] speed;
    logic [2:0] ratio;
    logic       locked;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit finished = 0;

    // reference model state
    int q[$];
    int m_cnt, m_armed, m_ratio, m_speed, m_lock, m_prev;
    int ev, c;

    always #2.5 clk = ~clk;

    mclk_rate_detect uut (
        .clk        (clk),
        .rst        (rst),
        .wclk_async (wclk),
        .speed_o    (speed),
        .ratio_o    (ratio),
        .locked_o   (locked)
    );

    function automatic int classify(int n);
        int noms[7] = '{128, 192, 256, 384, 512, 768, 1152};
        for (int i = 0; i < 7; i++)
            if (n >= noms[i] - 4 && n <= noms[i] + 4) return i + 1;
        return 0;
    endfunction

    function automatic int band(int r);
        if (r == 1 || r == 2) return 2;
        if (r == 3 || r == 4) return 1;
        return 0;
    endfunction

    // Behavioural model: a window closes two edges after wclk is first seen high (R8)
    always @(posedge clk) begin
        if (rst) begin
            q = '{0, 0, 0};
            m_cnt = 0; m_armed = 0; m_ratio = 0;
            m_speed = 0; m_lock = 0; m_prev = 0;
        end else begin
            ev = (q[1] == 1 && q[0] == 0) ? 1 : 0;
            if (ev == 1 && m_armed == 1) begin
                c = classify(m_cnt);
                m_ratio = c;
                if (c != 0 && c == m_prev) begin
                    m_lock = 1;
                    m_speed = band(c);
                end else begin
                    m_lock = 0;
                end
                m_prev = c;
            end else if (m_cnt == SAT) begin
                m_ratio = 0; m_prev = 0; m_lock = 0;
            end
            if (ev == 1) begin
                m_cnt = 1; m_armed = 1;
            end else if (m_cnt < SAT) begin
                m_cnt = m_cnt + 1;
            end
            q.push_back(int'(wclk));
            void'(q.pop_front());
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !rst) begin
            check("R2 R3 R8 ratio_o vs model", int'(ratio), m_ratio);
            check("R5 locked_o vs model", int'(locked), m_lock);
            check("R4 R6 speed_o vs model", int'(speed), m_speed);
        end
    end

    task automatic frames(int n, int k);
        for (int f = 0; f < k; f++) begin
            wclk = 1'b1;
            repeat (n / 2) @(negedge clk);
            wclk = 1'b0;
            repeat (n - n / 2) @(negedge clk);
        end
    endtask

    task automatic expect_out(string tag, int er, int es, int el);
        if (er >= 0) check({tag, " ratio"}, int'(ratio), er);
        if (es >= 0) check({tag, " speed"}, int'(speed), es);
        if (el >= 0) check({tag, " locked"}, int'(locked), el);
    endtask

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        expect_out("R1 reset", 0, 0, 0);
        rst = 1'b0;
        started = 1;
        repeat (3) @(negedge clk);

        frames(512, 2);
        expect_out("R9 first window", 5, 0, 0);
        frames(512, 2);
        expect_out("R2 R5 512", 5, 0, 1);
        frames(768, 4);
        expect_out("R2 R4 768", 6, 0, 1);
        frames(256, 4);
        expect_out("R2 R4 256", 3, 1, 1);
        frames(384, 4);
        expect_out("R2 R4 384", 4, 1, 1);
        frames(128, 4);
        expect_out("R2 R4 128", 1, 2, 1);
        frames(192, 4);
        expect_out("R2 R4 192", 2, 2, 1);
        frames(517, 4);
        expect_out("R3 R6 517 rejected", 0, 2, 0);
        frames(1152, 4);
        expect_out("R4 1152", 7, 0, 1);
        frames(508, 4);
        expect_out("R3 508", 5, 0, 1);
        frames(516, 4);
        expect_out("R3 516", 5, 0, 1);
        for (int a = 0; a < 3; a++) begin
            frames(512, 1);
            frames(768, 1);
        end
        expect_out("R5 R6 alternating", 5, 0, 0);
        wclk = 1'b0;
        repeat (1300) @(negedge clk);
        expect_out("R7 saturated", 0, 0, 0);
        frames(256, 4);
        expect_out("R7 recovery", 3, 1, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule